// File: doc/BRIEF.md
# PLL Lock Detector with Programmable Windows

This block watches the UP and DOWN outputs of a phase-frequency detector, one sample per reference clock, and decides whether the synthesizer loop is locked. Each period in which UP or DOWN has been held beyond a short guard window counts as a phase-error period. A run of phase-error periods longer than a programmable tolerance is an unlock event. A programmable count of consecutive periods free of unlock events declares lock. Both windows are powers of two, chosen by 2-bit codes.

Two observation styles are available. In one-shot mode the flag latches high at the first lock and only a disable clears it. In continuous mode every unlock event drops the flag again, and lock must then be earned anew. A single-cycle pulse marks each rising edge of the flag, so it can switch on a transmit power amplifier. The flag reaches the lock-detect pin only while the device runs in programmable mode. The pulse is not gated by that mode.

Top module: `pll_lock_det`

## Requirements
- R1: While `rst_n` is low, and one reference clock after any cycle with `enable` low, `lock_det` and `lock_rise` are 0. All counters restart from zero when `enable` returns.
- R2: A cycle is a phase-error cycle only when `pfd_up` or `pfd_dn` is high and that same input was also high in the previous GUARD_CYC cycles (default 1). With the default, pulses of a single cycle on either input, even alternating ones, never count as errors.
- R3: `unlock_sel` sets the tolerance T: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8, 2'b11 gives 16. An unlock event happens on the (T+1)th consecutive phase-error cycle. Any cycle without an error restarts the run.
- R4: `lockcnt_sel` sets the lock count L: 2'b00 gives 4, 2'b01 gives 16, 2'b10 gives 64, 2'b11 gives 256. The flag rises on the Lth clock edge that samples `enable` high, provided no unlock event occurred since enable or since the last unlock.
- R5: With `cont_mode` = 0 (one-shot), the flag stays high once set, whatever UP and DOWN do, until `enable` falls.
- R6: With `cont_mode` = 1 (continuous), an unlock event clears the flag on that same clock edge.
- R7: An unlock event restarts the lock count, so relocking takes L further clean cycles counted from the cycle after the last unlock event.
- R8: `lock_rise` is high for exactly one reference clock, in the cycle in which the flag first reads high after being low.
- R9: `lock_det` equals the internal flag when `prog_mode` is 1 and is 0 when `prog_mode` is 0; `lock_rise` is not affected by `prog_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; one phase-detector comparison per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Detector enable; low clears all state |
| pfd_up | input | 1 | UP pulse from the phase-frequency detector, synchronous to clk_ref |
| pfd_dn | input | 1 | DOWN pulse from the phase-frequency detector, synchronous to clk_ref |
| unlock_sel | input | 2 | Unlock tolerance code |
| lockcnt_sel | input | 2 | Lock count code |
| cont_mode | input | 1 | 1: continuous observation, 0: one-shot latch |
| prog_mode | input | 1 | 1: flag drives lock_det |
| lock_det | output | 1 | Lock-detect output |
| lock_rise | output | 1 | One-cycle pulse on the flag's rising transition |

## Verification
The assertions assume that UP and DOWN are already synchronous to the reference clock and that both codes and the observation mode stay fixed while `enable` is high. Under that assumption an unlock event always follows an error cycle and a rising flag always finds the clean-cycle count at its limit. The stimulus keeps to this by driving every input on the falling edge. It also changes `unlock_sel`, `lockcnt_sel` and `cont_mode` only in cycles where `enable` is low, in both the directed sequences and the random segments.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

   // Length of a power-of-two window selected by a 2-bit code.
   function automatic int unsigned win_len(input logic [1:0] code,
                                           input int unsigned base_log2,
                                           input int unsigned step_log2);
      return 32'd1 << (base_log2 + step_log2 * int'(code));
   endfunction

   // Width needed to hold the largest window of a 2-bit code family.
   function automatic int unsigned win_width(input int unsigned base_log2,
                                             input int unsigned step_log2);
      return base_log2 + 3 * step_log2 + 1;
   endfunction

   typedef enum logic {
      OBS_ONESHOT = 1'b0,
      OBS_CONT    = 1'b1
   } obs_mode_e;

endpackage

// File: rtl/lkd_lane.sv
module lkd_lane #(
   parameter int unsigned GUARD_CYC = 1
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic enable,
   input  logic pulse_in,
   output logic long_pulse
);
   localparam int unsigned GW = (GUARD_CYC < 1) ? 1 : $clog2(GUARD_CYC + 1);
   localparam logic [GW-1:0] GLIM = GW'(GUARD_CYC);

   logic [GW-1:0] wid_q;

   assign long_pulse = pulse_in && (wid_q >= GLIM);

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         wid_q <= '0;
      end else if (!enable || !pulse_in) begin
         wid_q <= '0;
      end else if (wid_q < GLIM) begin
         wid_q <= wid_q + 1'b1;
      end
   end

   generate
      if (GUARD_CYC >= 1) begin : g_guard_chk
         // R2: a pulse that has just started cannot be a phase error
         p_fresh_pulse_clean_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
            (pulse_in && !$past(pulse_in)) |-> !long_pulse);
      end
   endgenerate

endmodule

// File: rtl/lkd_err_track.sv
module lkd_err_track #(
   parameter int unsigned GUARD_CYC = 1,
   parameter int unsigned TOLW      = 5
) (
   input  logic            clk_ref,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            pfd_up,
   input  logic            pfd_dn,
   input  logic [TOLW-1:0] tol_len,
   output logic            unlock_ev
);
   localparam int unsigned NLANE = 2;

   logic [NLANE-1:0] lane_in;
   logic [NLANE-1:0] lane_err;
   logic             err_now;
   logic [TOLW-1:0]  erun_q;

   assign lane_in = {pfd_dn, pfd_up};

   generate
      for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
         lkd_lane #(.GUARD_CYC(GUARD_CYC)) u_lane (
            .clk_ref   (clk_ref),
            .rst_n     (rst_n),
            .enable    (enable),
            .pulse_in  (lane_in[gi]),
            .long_pulse(lane_err[gi])
         );
      end
   endgenerate

   assign err_now   = |lane_err;
   assign unlock_ev = err_now && (erun_q >= tol_len);

   // Consecutive phase-error periods, saturating at the tolerance.
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         erun_q <= '0;
      end else if (!enable || !err_now) begin
         erun_q <= '0;
      end else if (erun_q < tol_len) begin
         erun_q <= erun_q + 1'b1;
      end
   end

   // R3: an unlock event is always the tail of an error run
   p_unlock_after_run_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      unlock_ev |-> ($past(err_now) && $past(enable)));

endmodule

// File: rtl/lkd_good_cnt.sv
module lkd_good_cnt #(
   parameter int unsigned LCW = 9
) (
   input  logic           clk_ref,
   input  logic           rst_n,
   input  logic           enable,
   input  logic           unlock_ev,
   input  logic [LCW-1:0] lock_len,
   output logic [LCW-1:0] good_q,
   output logic           lock_hit
);
   logic [LCW:0] next_val;

   assign next_val = {1'b0, good_q} + 1'b1;
   assign lock_hit = enable && !unlock_ev && (next_val >= {1'b0, lock_len});

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         good_q <= '0;
      end else if (!enable || unlock_ev) begin
         good_q <= '0;
      end else if (good_q < lock_len) begin
         good_q <= good_q + 1'b1;
      end
   end

   // R7: an unlock event restarts the clean-cycle count
   p_unlock_restarts_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (enable && unlock_ev) |=> (good_q == '0));

endmodule

// File: rtl/lkd_flag_ctrl.sv
module lkd_flag_ctrl
   import lkd_pkg::*;
(
   input  logic clk_ref,
   input  logic rst_n,
   input  logic enable,
   input  logic cont_mode,
   input  logic unlock_ev,
   input  logic lock_hit,
   output logic flag_q,
   output logic pulse_q
);
   obs_mode_e obs;
   logic      flag_d;

   assign obs = obs_mode_e'(cont_mode);

   always_comb begin
      if (!enable) begin
         flag_d = 1'b0;
      end else if (obs == OBS_CONT) begin
         flag_d = !unlock_ev && (flag_q || lock_hit);
      end else begin
         flag_d = flag_q || lock_hit;
      end
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         flag_q  <= flag_d;
         pulse_q <= flag_d && !flag_q;
      end
   end

   // R1: disable clears both outputs within one clock
   p_disable_clears_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !enable |=> (!flag_q && !pulse_q));
   // R5: one-shot mode holds the flag while enabled
   p_oneshot_hold_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (enable && !cont_mode && flag_q) |=> flag_q);
   // R6: continuous mode drops the flag on unlock
   p_cont_unlock_drop_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (enable && cont_mode && unlock_ev) |=> !flag_q);
   // R8: pulse marks the rising transition and lasts one cycle
   p_pulse_on_rise_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(flag_q) |-> pulse_q);
   p_pulse_single_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det
   import lkd_pkg::*;
#(
   parameter int unsigned GUARD_CYC      = 1,
   parameter int unsigned TOL_BASE_LOG2  = 1,
   parameter int unsigned TOL_STEP_LOG2  = 1,
   parameter int unsigned LOCK_BASE_LOG2 = 2,
   parameter int unsigned LOCK_STEP_LOG2 = 2
) (
   input  logic       clk_ref,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       pfd_up,
   input  logic       pfd_dn,
   input  logic [1:0] unlock_sel,
   input  logic [1:0] lockcnt_sel,
   input  logic       cont_mode,
   input  logic       prog_mode,
   output logic       lock_det,
   output logic       lock_rise
);
   localparam int unsigned TOLW = win_width(TOL_BASE_LOG2, TOL_STEP_LOG2);
   localparam int unsigned LCW  = win_width(LOCK_BASE_LOG2, LOCK_STEP_LOG2);

   generate
      if (GUARD_CYC > 255) begin : g_bad_guard
         $error("pll_lock_det: GUARD_CYC out of range");
      end
      if (TOLW > 24) begin : g_bad_tol
         $error("pll_lock_det: unlock window too wide");
      end
      if (LCW > 24) begin : g_bad_lock
         $error("pll_lock_det: lock window too wide");
      end
   endgenerate

   logic [TOLW-1:0] tol_len;
   logic [LCW-1:0]  lock_len;
   logic            unlock_ev;
   logic            lock_hit;
   logic [LCW-1:0]  good_q;
   logic            flag_q;

   assign tol_len  = TOLW'(win_len(unlock_sel, TOL_BASE_LOG2, TOL_STEP_LOG2));
   assign lock_len = LCW'(win_len(lockcnt_sel, LOCK_BASE_LOG2, LOCK_STEP_LOG2));

   lkd_err_track #(.GUARD_CYC(GUARD_CYC), .TOLW(TOLW)) u_err (
      .clk_ref  (clk_ref),
      .rst_n    (rst_n),
      .enable   (enable),
      .pfd_up   (pfd_up),
      .pfd_dn   (pfd_dn),
      .tol_len  (tol_len),
      .unlock_ev(unlock_ev)
   );

   lkd_good_cnt #(.LCW(LCW)) u_good (
      .clk_ref  (clk_ref),
      .rst_n    (rst_n),
      .enable   (enable),
      .unlock_ev(unlock_ev),
      .lock_len (lock_len),
      .good_q   (good_q),
      .lock_hit (lock_hit)
   );

   lkd_flag_ctrl u_flag (
      .clk_ref  (clk_ref),
      .rst_n    (rst_n),
      .enable   (enable),
      .cont_mode(cont_mode),
      .unlock_ev(unlock_ev),
      .lock_hit (lock_hit),
      .flag_q   (flag_q),
      .pulse_q  (lock_rise)
   );

   assign lock_det = flag_q && prog_mode;

   // R4: the flag only rises once the clean-cycle count has reached its window
   p_rise_needs_count_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(flag_q) |-> (good_q >= lock_len));

endmodule

// File: tb/tb_pll_lock_det.sv
module tb_pll_lock_det;
   logic       clk_ref = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       pfd_up = 1'b0;
   logic       pfd_dn = 1'b0;
   logic [1:0] unlock_sel = 2'b01;
   logic [1:0] lockcnt_sel = 2'b01;
   logic       cont_mode = 1'b1;
   logic       prog_mode = 1'b1;
   logic       lock_det;
   logic       lock_rise;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   bit cmp_on = 0;
   string cur_req = "R1";

   // reference model state
   int m_upw = 0, m_dnw = 0, m_erun = 0, m_good = 0;
   bit m_flag = 0, m_pulse = 0;
   localparam int G = 1;

   always #10 clk_ref = ~clk_ref;

   pll_lock_det dut (
      .clk_ref(clk_ref), .rst_n(rst_n), .enable(enable),
      .pfd_up(pfd_up), .pfd_dn(pfd_dn),
      .unlock_sel(unlock_sel), .lockcnt_sel(lockcnt_sel),
      .cont_mode(cont_mode), .prog_mode(prog_mode),
      .lock_det(lock_det), .lock_rise(lock_rise)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   // behavioural model, compared every cycle
   always @(posedge clk_ref) begin
      int t_len, l_len;
      bit e, u, nf;
      if (!rst_n || !enable) begin
         m_upw = 0; m_dnw = 0; m_erun = 0; m_good = 0;
         m_flag = 0; m_pulse = 0;
      end else begin
         t_len = 2 << unlock_sel;
         l_len = 4 << (2 * lockcnt_sel);
         e = (pfd_up && m_upw >= G) || (pfd_dn && m_dnw >= G);
         u = e && (m_erun >= t_len);
         m_upw = pfd_up ? ((m_upw < G) ? m_upw + 1 : m_upw) : 0;
         m_dnw = pfd_dn ? ((m_dnw < G) ? m_dnw + 1 : m_dnw) : 0;
         m_erun = e ? ((m_erun < t_len) ? m_erun + 1 : m_erun) : 0;
         m_good = u ? 0 : ((m_good < l_len) ? m_good + 1 : m_good);
         if (cont_mode) nf = !u && (m_flag || (m_good >= l_len));
         else           nf = m_flag || (!u && (m_good >= l_len));
         m_pulse = nf && !m_flag;
         m_flag = nf;
      end
      #5;
      if (cmp_on) begin
         check({cur_req, " model lock_det"}, int'(lock_det), int'(m_flag && prog_mode));
         check({cur_req, " model lock_rise"}, int'(lock_rise), int'(m_pulse));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk_ref);
   endtask

   task automatic wait_rise(input int max_c, output int got);
      got = -1;
      for (int c = 1; c <= max_c; c++) begin
         @(posedge clk_ref); #6;
         if (lock_rise) begin
            got = c;
            return;
         end
      end
   endtask

   task automatic restart(input logic [1:0] us, input logic [1:0] ls, input logic cm);
      @(negedge clk_ref);
      enable = 0; pfd_up = 0; pfd_dn = 0;
      @(negedge clk_ref);
      unlock_sel = us; lockcnt_sel = ls; cont_mode = cm;
      @(negedge clk_ref);
      enable = 1;
   endtask

   initial begin
      #(200000 * 20);
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int got;
      cyc(3);
      #1;
      check("R1 reset lock_det", int'(lock_det), 0);
      check("R1 reset lock_rise", int'(lock_rise), 0);
      rst_n = 1;
      cmp_on = 1;

      // R4 + R8: lock window for each code
      cur_req = "R4";
      for (int k = 0; k < 4; k++) begin
         restart(2'b01, 2'(k), 1'b1);
         wait_rise(300, got);
         check("R4 lock cycles", got, 4 << (2 * k));
         check("R4 lock_det high", int'(lock_det), 1);
         @(posedge clk_ref); #6;
         check("R8 pulse width", int'(lock_rise), 0);
         @(negedge clk_ref); enable = 0;
         @(posedge clk_ref); #6;
         check("R1 disable clears", int'(lock_det), 0);
      end

      // R2: alternating single-cycle pulses are not errors
      cur_req = "R2";
      restart(2'b00, 2'b00, 1'b1);
      wait_rise(10, got);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk_ref);
         pfd_up = (i % 2 == 0); pfd_dn = (i % 2 == 1);
      end
      @(negedge clk_ref); pfd_up = 0; pfd_dn = 0; #1;
      check("R2 alternating pulses keep lock", int'(lock_det), 1);

      // R3 + R6: tolerance for each unlock code
      for (int k = 0; k < 4; k++) begin
         int t_len;
         t_len = 2 << k;
         cur_req = "R3";
         restart(2'(k), 2'b00, 1'b1);
         wait_rise(10, got);
         check("R3 pre-lock", got, 4);
         @(negedge clk_ref); pfd_dn = 1;
         cyc(t_len + 1);
         pfd_dn = 0; #1;
         check("R3 T error cycles tolerated", int'(lock_det), 1);
         @(negedge clk_ref); pfd_up = 1;
         cur_req = "R6";
         cyc(t_len + 2);
         pfd_up = 0; #1;
         check("R6 unlock drops flag", int'(lock_det), 0);
         cyc(6);
      end

      // R3: interrupted runs never unlock
      cur_req = "R3";
      restart(2'b00, 2'b00, 1'b1);
      wait_rise(10, got);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk_ref); pfd_up = 1;
         cyc(3);
         pfd_up = 0;
      end
      #1;
      check("R3 broken runs keep lock", int'(lock_det), 1);

      // R7: relock needs a full window after the last unlock
      cur_req = "R7";
      restart(2'b00, 2'b01, 1'b1);
      wait_rise(40, got);
      check("R7 first lock", got, 16);
      @(negedge clk_ref); pfd_up = 1;
      cyc(6);
      pfd_up = 0;
      wait_rise(40, got);
      check("R7 relock cycles", got, 16);

      // R5: one-shot holds through a long error run
      cur_req = "R5";
      restart(2'b00, 2'b00, 1'b0);
      wait_rise(10, got);
      @(negedge clk_ref); pfd_up = 1; pfd_dn = 1;
      cyc(30);
      pfd_up = 0; pfd_dn = 0; #1;
      check("R5 one-shot holds", int'(lock_det), 1);
      @(negedge clk_ref); enable = 0;
      @(posedge clk_ref); #6;
      check("R1 one-shot cleared by disable", int'(lock_det), 0);

      // R9: pin gating by programmable mode
      cur_req = "R9";
      @(negedge clk_ref); prog_mode = 0;
      restart(2'b00, 2'b00, 1'b1);
      wait_rise(10, got);
      check("R9 pulse ungated", got, 4);
      check("R9 pin gated off", int'(lock_det), 0);
      @(negedge clk_ref); prog_mode = 1; #1;
      check("R9 pin follows flag", int'(lock_det), 1);

      // random segments against the model
      cur_req = "R3";
      for (int s = 0; s < 40; s++) begin
         @(negedge clk_ref); enable = 0; pfd_up = 0; pfd_dn = 0;
         @(negedge clk_ref);
         unlock_sel = 2'($urandom % 4);
         lockcnt_sel = 2'($urandom % 3);
         cont_mode = 1'($urandom % 2);
         prog_mode = 1'($urandom % 2);
         @(negedge clk_ref); enable = 1;
         for (int i = 0; i < 200; i++) begin
            @(negedge clk_ref);
            if ($urandom % 6 == 0) pfd_up = ~pfd_up;
            if ($urandom % 7 == 0) pfd_dn = ~pfd_dn;
            if (pfd_up && ($urandom % 20 == 0)) pfd_up = 0;
         end
      end

      cyc(2);
      finish_run();
   end
endmodule